// File: doc/BRIEF.md
# Three-wire serial EEPROM host controller

This block is the master side of a three-wire serial EEPROM link (select, clock, data in, data out). A user-side request carries a command code, a 4-bit word address and a 16-bit write word. The block turns that request into one serial instruction frame. It generates the serial clock from the system clock with programmable low and high half-periods and shifts the frame out MSB first. For reads, it collects the returned word.

Some commands start a self-timed programming cycle in the memory: write, erase, erase-all and write-all. After these, the controller drops select and waits out the minimum select-low gap. It then raises select again and watches the data-out line until the memory reports ready, and only then signals completion. If ready never comes within a bounded number of cycles, it gives up and flags an error.

Every instruction is separated from the previous one by a guaranteed select-low time, counted in system clocks.

Top module: `sep_host`

## Requirements
- R1: Each frame is a 1 start bit, two opcode bits and a six-bit field, all MSB first. The command codes on `req_op` map as follows:
  - 0 = read (opcode 10, field 00 then address)
  - 1 = write (01, 00+address)
  - 2 = erase (11, 00+address)
  - 3 = write enable (00, field 110000)
  - 4 = write disable (00, 000000)
  - 5 = erase-all (00, 100000)
  - 6 = write-all (00, 010000)
  - 7 = sent as write disable
- R2: `ee_di` changes only while `ee_sk` is low and holds its value across every high phase of `ee_sk`.
- R3: The frame carries 25 rising clock edges for read, write and write-all (write and write-all append the 16-bit word MSB first) and 9 rising edges for all other codes.
- R4: On a read, the bit present after the 9th edge (a dummy zero) is discarded. The next 16 bits, MSB first, become `rdata`. `rdata` changes only when a read completes.
- R5: Before every rising edge of `ee_cs`, `ee_cs` has been low for at least CS_GAP system clocks, including the first rise after reset.
- R6: After the frame of a write, erase, erase-all or write-all, `ee_cs` drops, rises again after the gap, and stays high with `ee_sk` low. `done` is raised only once `ee_do` reads 1, so such a request produces exactly two select-high windows.
- R7: Read, enable and disable requests are not followed by a status poll. Their single select-high window ends in the same cycle that `done` goes high.
- R8: Within a select-high window, each low phase of `ee_sk` lasts CLK_LO system clocks and each high phase lasts CLK_HI system clocks. `ee_sk` is low whenever `ee_cs` is low.
- R9: A request is taken only when `req_valid` is high and `busy` is low. `busy` is high in the following cycle. A `req_valid` seen while `busy` is high has no effect.
- R10: `done` is a one-cycle pulse, and `busy` is low in the cycle after it.
- R11: If `ee_do` stays 0 for POLL_LIMIT cycles of polling, `ee_cs` drops and `done` pulses with `err` high. `err` holds until the next request is taken, which clears it.
- R12: While reset is asserted, all outputs (`ee_cs`, `ee_sk`, `ee_di`, `busy`, `done`, `err`, `rdata`) are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Command code (see R1) |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Word for write and write-all |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Status poll timed out |
| rdata | output | DATA_W | Last word read |
| ee_cs | output | 1 | Serial select |
| ee_sk | output | 1 | Serial clock |
| ee_di | output | 1 | Serial data to the memory |
| ee_do | input | 1 | Serial data and ready status from the memory |

## Verification
`busy` is due one cycle after the request is taken. `done` and `rdata` are due in the very cycle that the final select window closes, and `busy` falls one cycle later. The bench drives inputs and samples outputs on the falling system edge. It waits for `done` and reads its bus-monitor counts one cycle afterwards, so that the monitor has recorded the closing window before they are compared. The serial timing is checked at every sample by the monitor: half-period lengths, data stability in high phases, select gaps, and edges per window. Expected read words come from a table built on the write history.

// File: rtl/sep_pkg.sv
`timescale 1ns/1ps
// Shared types for the three-wire serial EEPROM host controller.
package sep_pkg;
    // User command codes carried on req_op.
    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_WRITE = 3'd1,
        OP_ERASE = 3'd2,
        OP_WREN  = 3'd3,
        OP_WRDIS = 3'd4,
        OP_ERALL = 3'd5,
        OP_WRALL = 3'd6
    } op_e;

    // Sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_SHIFT,
        ST_PGAP,
        ST_POLL,
        ST_DONE
    } state_e;
endpackage

// File: rtl/sep_frame.sv
`timescale 1ns/1ps
// sep_frame: builds the serial instruction frame for a command code.
// Output is left-aligned: start bit, opcode, field, then the data word.
// Assumes the caller latches the frame when the request is taken.
module sep_frame #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    localparam int FIELD_W = ADDR_W + 2,
    localparam int HDR_W   = 3 + FIELD_W,
    localparam int FRAME_W = HDR_W + DATA_W,
    localparam int EC_W    = $clog2(FRAME_W + 1)
) (
    input  logic [2:0]         op_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [FRAME_W-1:0] frame_o,
    output logic [EC_W-1:0]    edges_o,
    output logic               read_o,
    output logic               prog_o
);
    import sep_pkg::*;

    localparam logic [EC_W-1:0] LONG_N  = EC_W'(FRAME_W);
    localparam logic [EC_W-1:0] SHORT_N = EC_W'(HDR_W);

    logic [1:0]         opc;
    logic [FIELD_W-1:0] field;
    logic [DATA_W-1:0]  payload;
    logic               long_f;

    // Decode the command code into opcode, field and frame kind.
    always_comb begin
        opc     = 2'b00;
        field   = '0;
        payload = '0;
        long_f  = 1'b0;
        read_o  = 1'b0;
        prog_o  = 1'b0;
        case (op_i)
            OP_READ: begin
                opc = 2'b10; field = {2'b00, addr_i}; long_f = 1'b1; read_o = 1'b1;
            end
            OP_WRITE: begin
                opc = 2'b01; field = {2'b00, addr_i}; long_f = 1'b1; prog_o = 1'b1;
                payload = wdata_i;
            end
            OP_ERASE: begin
                opc = 2'b11; field = {2'b00, addr_i}; prog_o = 1'b1;
            end
            OP_WREN: begin
                field = {2'b11, {ADDR_W{1'b0}}};
            end
            OP_ERALL: begin
                field = {2'b10, {ADDR_W{1'b0}}}; prog_o = 1'b1;
            end
            OP_WRALL: begin
                field = {2'b01, {ADDR_W{1'b0}}}; long_f = 1'b1; prog_o = 1'b1;
                payload = wdata_i;
            end
            default: begin
                field = {2'b00, {ADDR_W{1'b0}}};
            end
        endcase
    end

    // Assemble the frame and its rising-edge count.
    always_comb begin
        frame_o = {1'b1, opc, field, payload};
        edges_o = long_f ? LONG_N : SHORT_N;
    end
endmodule

// File: rtl/sep_bitclk.sv
`timescale 1ns/1ps
// sep_bitclk: serial clock generator with separate low and high lengths.
// While run_i is low the clock is held low and the phase count cleared.
// rise_o/fall_o mark the system cycle at whose end the clock changes.
module sep_bitclk #(
    parameter int LO_DIV = 2,
    parameter int HI_DIV = 2,
    localparam int PH_MAX = (LO_DIV > HI_DIV) ? LO_DIV : HI_DIV,
    localparam int PH_W   = (PH_MAX > 1) ? $clog2(PH_MAX) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic sk_o,
    output logic rise_o,
    output logic fall_o
);
    logic [PH_W-1:0] ph;

    // End-of-phase strobes.
    always_comb begin
        rise_o = run_i && !sk_o && (ph == PH_W'(LO_DIV - 1));
        fall_o = run_i &&  sk_o && (ph == PH_W'(HI_DIV - 1));
    end

    // Phase counter and clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph   <= '0;
            sk_o <= 1'b0;
        end else if (!run_i) begin
            ph   <= '0;
            sk_o <= 1'b0;
        end else if (rise_o) begin
            ph   <= '0;
            sk_o <= 1'b1;
        end else if (fall_o) begin
            ph   <= '0;
            sk_o <= 1'b0;
        end else begin
            ph   <= ph + 1'b1;
        end
    end

    // Low and high phases have the programmed lengths.
    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (sk_o ? (ph < PH_W'(HI_DIV)) : (ph < PH_W'(LO_DIV)))); // R8
endmodule

// File: rtl/sep_csgap.sv
`timescale 1ns/1ps
// sep_csgap: counts system clocks with select low, saturating at GAP.
// ok_o says the minimum select-low time has elapsed. The count starts
// at zero after reset, so the first select rise also waits.
module sep_csgap #(
    parameter int GAP = 4,
    localparam int G_W = $clog2(GAP + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    output logic ok_o
);
    logic [G_W-1:0] cnt;

    // Low-time counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= '0;
        else if (cs_i)               cnt <= '0;
        else if (cnt != G_W'(GAP))   cnt <= cnt + 1'b1;
    end

    // Gap reached.
    always_comb ok_o = (cnt == G_W'(GAP));

    // The count cannot pass its limit.
    AST_GAP_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_o && !cs_i) |=> ok_o); // R5
endmodule

// File: rtl/sep_host.sv
`timescale 1ns/1ps
// sep_host: three-wire serial EEPROM host controller.
// Runs one instruction per request: select gap, frame shift, optional
// ready poll, then a done pulse. Assumes ee_do is synchronous to clk.
module sep_host #(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 16,
    parameter int CLK_LO     = 2,
    parameter int CLK_HI     = 2,
    parameter int CS_GAP     = 4,
    parameter int POLL_LIMIT = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rdata,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do
);
    import sep_pkg::*;

    localparam int FIELD_W = ADDR_W + 2;
    localparam int HDR_W   = 3 + FIELD_W;
    localparam int FRAME_W = HDR_W + DATA_W;
    localparam int EC_W    = $clog2(FRAME_W + 1);
    localparam int PC_W    = $clog2(POLL_LIMIT + 1);

    state_e             state;
    logic               cs_q;
    logic [FRAME_W-1:0] tx;
    logic [DATA_W-1:0]  rx;
    logic [DATA_W-1:0]  rdata_q;
    logic [EC_W-1:0]    edge_cnt;
    logic [EC_W-1:0]    n_edges;
    logic               is_read;
    logic               is_prog;
    logic [PC_W-1:0]    poll_cnt;
    logic               err_q;

    logic [FRAME_W-1:0] f_frame;
    logic [EC_W-1:0]    f_edges;
    logic               f_read;
    logic               f_prog;
    logic               gap_ok;
    logic               sk_rise;
    logic               sk_fall;
    logic               run;

    sep_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
        .op_i    (req_op),
        .addr_i  (req_addr),
        .wdata_i (req_wdata),
        .frame_o (f_frame),
        .edges_o (f_edges),
        .read_o  (f_read),
        .prog_o  (f_prog)
    );

    sep_bitclk #(.LO_DIV(CLK_LO), .HI_DIV(CLK_HI)) u_bitclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .sk_o   (ee_sk),
        .rise_o (sk_rise),
        .fall_o (sk_fall)
    );

    sep_csgap #(.GAP(CS_GAP)) u_csgap (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_i  (cs_q),
        .ok_o  (gap_ok)
    );

    // Output and control decode from the state.
    always_comb begin
        run   = (state == ST_SHIFT);
        busy  = (state != ST_IDLE);
        done  = (state == ST_DONE);
        err   = err_q;
        rdata = rdata_q;
        ee_cs = cs_q;
        ee_di = (state == ST_SHIFT) ? tx[FRAME_W-1] : 1'b0;
    end

    // Main sequencer: gap, shift, program poll, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cs_q     <= 1'b0;
            tx       <= '0;
            rx       <= '0;
            rdata_q  <= '0;
            edge_cnt <= '0;
            n_edges  <= '0;
            is_read  <= 1'b0;
            is_prog  <= 1'b0;
            poll_cnt <= '0;
            err_q    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        tx      <= f_frame;
                        n_edges <= f_edges;
                        is_read <= f_read;
                        is_prog <= f_prog;
                        err_q   <= 1'b0;
                        state   <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (gap_ok) begin
                        cs_q     <= 1'b1;
                        edge_cnt <= '0;
                        state    <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (sk_rise) edge_cnt <= edge_cnt + 1'b1;
                    if (sk_fall) begin
                        tx <= {tx[FRAME_W-2:0], 1'b0};
                        if (is_read && (edge_cnt > EC_W'(HDR_W)))
                            rx <= {rx[DATA_W-2:0], ee_do};
                        if (edge_cnt == n_edges) begin
                            cs_q <= 1'b0;
                            if (is_read) rdata_q <= {rx[DATA_W-2:0], ee_do};
                            state <= is_prog ? ST_PGAP : ST_DONE;
                        end
                    end
                end
                ST_PGAP: begin
                    if (gap_ok) begin
                        cs_q     <= 1'b1;
                        poll_cnt <= '0;
                        state    <= ST_POLL;
                    end
                end
                ST_POLL: begin
                    if ((poll_cnt != '0) && ee_do) begin
                        cs_q  <= 1'b0;
                        state <= ST_DONE;
                    end else if (poll_cnt == PC_W'(POLL_LIMIT)) begin
                        cs_q  <= 1'b0;
                        err_q <= 1'b1;
                        state <= ST_DONE;
                    end else begin
                        poll_cnt <= poll_cnt + 1'b1;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_DI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_sk && $past(ee_sk)) |-> $stable(ee_di)); // R2
    AST_EDGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT) |-> (edge_cnt <= n_edges)); // R3
    AST_GAP_BEFORE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_cs) |-> $past(gap_ok)); // R5
    AST_DONE_AT_CS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $fell(ee_cs)); // R7
    AST_SK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_cs |-> !ee_sk); // R8
    AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R10
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done); // R11
endmodule

// File: tb/sep_host_bench.sv
`timescale 1ns/1ps
module sep_host_bench;
    localparam int LO = 2;
    localparam int HI = 3;
    localparam int GAP = 5;
    localparam int PLIM = 300;
    localparam int PROG = 20;
    localparam int NV = 21;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [2:0] req_op = '0;
    logic [3:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic busy, done, err, ee_cs, ee_sk, ee_di, ee_do;
    logic [15:0] rdata;

    always #2.5 clk = ~clk;

    sep_host #(.ADDR_W(4), .DATA_W(16), .CLK_LO(LO), .CLK_HI(HI),
               .CS_GAP(GAP), .POLL_LIMIT(PLIM)) u_sep_host (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .err(err), .rdata(rdata), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
        .ee_do(ee_do));

    int n_checks = 0;
    int n_err = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Memory model driven by the serial bus.
    logic [15:0] mem [16];
    logic [8:0]  m_hdr = '0;
    logic [15:0] m_wd = '0;
    logic [15:0] m_rsh = '0;
    int          m_cnt = 0;
    logic        m_rd = 1'b0;
    logic        m_do = 1'b0;
    logic        m_en = 1'b0;
    logic        m_stuck = 1'b0;
    int          m_busy = 0;

    initial for (int i = 0; i < 16; i++) mem[i] = 16'hFFFF;

    assign ee_do = m_rd ? m_do : !((m_busy > 0) || m_stuck);

    always @(posedge ee_sk) begin
        if (ee_cs && !(m_cnt == 0 && !ee_di)) begin
            m_cnt++;
            if (m_cnt <= 9) m_hdr = {m_hdr[7:0], ee_di};
            else            m_wd  = {m_wd[14:0], ee_di};
            if (m_cnt == 9) begin
                if (m_hdr[7:6] == 2'b10) begin
                    m_rd = 1'b1; m_rsh = mem[m_hdr[3:0]]; m_do = 1'b0;
                end else if (m_hdr[7:6] == 2'b00) begin
                    if (m_hdr[5:4] == 2'b11) m_en = 1'b1;
                    else if (m_hdr[5:4] == 2'b00) m_en = 1'b0;
                end
            end else if (m_cnt > 9 && m_rd) begin
                m_do = m_rsh[15]; m_rsh = {m_rsh[14:0], 1'b0};
            end
        end
    end

    always @(negedge ee_cs) begin
        if (m_en && m_cnt == 25 && m_hdr[7:6] == 2'b01) begin
            mem[m_hdr[3:0]] = m_wd; m_busy = PROG;
        end else if (m_en && m_cnt == 9 && m_hdr[7:6] == 2'b11) begin
            mem[m_hdr[3:0]] = 16'hFFFF; m_busy = PROG;
        end else if (m_en && m_cnt == 9 && m_hdr[7:4] == 4'b0010) begin
            for (int i = 0; i < 16; i++) mem[i] = 16'hFFFF;
            m_busy = PROG;
        end else if (m_en && m_cnt == 25 && m_hdr[7:4] == 4'b0001) begin
            for (int i = 0; i < 16; i++) mem[i] = m_wd;
            m_busy = PROG;
        end
        m_cnt = 0; m_rd = 1'b0;
    end

    always @(posedge clk) if (m_busy > 0) m_busy = m_busy - 1;

    // Bus monitor, sampled on the falling system edge.
    logic p_cs = 0, p_sk = 0, p_di = 0, p_done = 0;
    int run_len = 0, low_len = 0, cur_edges = 0;
    int t_wins = 0, t_first = 0, t_edges = 0, t_dones = 0;
    int v_gap = 0, v_time = 0, v_di = 0, v_idle = 0, v_pulse = 0, v_dcs = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (ee_cs && !p_cs) begin
                t_wins++; cur_edges = 0; run_len = 1;
                if (low_len < GAP) v_gap++;
                low_len = 0;
            end else if (ee_cs && p_cs) begin
                if (ee_sk != p_sk) begin
                    if (p_sk && run_len != HI) v_time++;
                    if (!p_sk && run_len != LO) v_time++;
                    if (ee_sk) cur_edges++;
                    run_len = 1;
                end else run_len++;
                if (ee_sk && p_sk && ee_di != p_di) v_di++;
            end
            if (!ee_cs && p_cs) begin
                if (t_wins == 1) t_first = cur_edges;
                t_edges += cur_edges;
            end
            if (!ee_cs) low_len++;
            if (!ee_cs && ee_sk) v_idle++;
            if (done) begin
                t_dones++;
                if (p_done) v_pulse++;
                if (!(p_cs && !ee_cs)) v_dcs++;
            end
        end
        p_cs = ee_cs; p_sk = ee_sk; p_di = ee_di; p_done = done;
    end

    // Command codes (R1).
    localparam logic [2:0] C_RD = 3'd0, C_WR = 3'd1, C_ER = 3'd2, C_EN = 3'd3,
                           C_DS = 3'd4, C_EA = 3'd5, C_WA = 3'd6, C_X7 = 3'd7;

    function automatic int wins_for(input logic [2:0] op);
        return (op == C_WR || op == C_ER || op == C_EA || op == C_WA) ? 2 : 1;
    endfunction

    // op, addr, wdata, expected rdata after the request, expected edges
    localparam logic [43:0] VEC [0:NV-1] = '{
        {C_EN, 4'h0, 16'h0000, 16'h0000, 5'd9},
        {C_WR, 4'h3, 16'h1234, 16'h0000, 5'd25},
        {C_RD, 4'h3, 16'h0000, 16'h1234, 5'd25},
        {C_WR, 4'h5, 16'h8001, 16'h1234, 5'd25},
        {C_RD, 4'h5, 16'h0000, 16'h8001, 5'd25},
        {C_ER, 4'h3, 16'h0000, 16'h8001, 5'd9},
        {C_RD, 4'h3, 16'h0000, 16'hFFFF, 5'd25},
        {C_DS, 4'h0, 16'h0000, 16'hFFFF, 5'd9},
        {C_WR, 4'h5, 16'h0000, 16'hFFFF, 5'd25},
        {C_RD, 4'h5, 16'h0000, 16'h8001, 5'd25},
        {C_EN, 4'h0, 16'h0000, 16'h8001, 5'd9},
        {C_WA, 4'h0, 16'h5A5A, 16'h8001, 5'd25},
        {C_RD, 4'h0, 16'h0000, 16'h5A5A, 5'd25},
        {C_RD, 4'hF, 16'h0000, 16'h5A5A, 5'd25},
        {C_EA, 4'h0, 16'h0000, 16'h5A5A, 5'd9},
        {C_RD, 4'h9, 16'h0000, 16'hFFFF, 5'd25},
        {C_WR, 4'hC, 16'h0001, 16'hFFFF, 5'd25},
        {C_RD, 4'hC, 16'h0000, 16'h0001, 5'd25},
        {C_X7, 4'h0, 16'h0000, 16'h0001, 5'd9},
        {C_WR, 4'h2, 16'h7E00, 16'h0001, 5'd25},
        {C_RD, 4'h2, 16'h0000, 16'hFFFF, 5'd25}
    };

    logic [15:0] r_rd;
    logic r_err;
    int r_cyc;

    task automatic issue(input logic [2:0] op, input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        while (busy) @(negedge clk);
        t_wins = 0; t_first = 0; t_edges = 0; t_dones = 0;
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R9 busy after accept", busy, 1);
    endtask

    task automatic finish_op();
        r_cyc = 0;
        while (!done && r_cyc < 20000) begin @(negedge clk); r_cyc++; end
        r_rd = rdata; r_err = err;
        chk(done == 1'b1, "R10 done seen", done, 1);
        chk(m_busy == 0, "R6 done only when ready", m_busy, 0);
        @(negedge clk);
        chk(!done && !busy, "R10 done single, busy low after", {done, busy}, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk({ee_cs, ee_sk, ee_di, busy, done, err} == 6'b0, "R12 reset outputs",
            {ee_cs, ee_sk, ee_di, busy, done, err}, 0);
        chk(rdata == 16'h0, "R12 reset rdata", rdata, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [43:0] v;
            v = VEC[i];
            issue(v[43:41], v[40:37], v[36:21]);
            finish_op();
            chk(r_rd == v[20:5], "R1 R4 read word / hold", r_rd, v[20:5]);
            chk(t_first == int'(v[4:0]), "R3 edges in frame", t_first, v[4:0]);
            chk(t_edges == t_first, "R6 no clock in poll", t_edges, t_first);
            chk(t_wins == wins_for(v[43:41]), "R6 R7 select windows", t_wins, wins_for(v[43:41]));
            chk(t_dones == 1, "R10 one done", t_dones, 1);
            chk(r_err == 1'b0, "R11 no error", r_err, 0);
        end

        // Request while busy is ignored (R9).
        issue(C_EN, 4'h0, 16'h0);
        finish_op();
        issue(C_RD, 4'h7, 16'h0);
        repeat (10) @(negedge clk);
        req_valid = 1'b1; req_op = C_WR; req_addr = 4'h7; req_wdata = 16'h0000;
        @(negedge clk);
        req_valid = 1'b0;
        finish_op();
        chk(t_dones == 1 && t_wins == 1, "R9 extra request ignored", {t_dones[7:0], t_wins[7:0]}, 16'h0101);
        chk(r_rd == 16'hFFFF, "R9 read during ignore", r_rd, 16'hFFFF);
        issue(C_RD, 4'h7, 16'h0);
        finish_op();
        chk(r_rd == 16'hFFFF, "R9 ignored write left word", r_rd, 16'hFFFF);

        // Poll timeout (R11).
        m_stuck = 1'b1;
        issue(C_WR, 4'h1, 16'h1111);
        finish_op();
        chk(r_err == 1'b1, "R11 timeout error", r_err, 1);
        chk(r_cyc >= PLIM, "R11 timeout length", r_cyc, PLIM);
        chk(t_wins == 2, "R11 windows on timeout", t_wins, 2);
        chk(err == 1'b1, "R11 err held", err, 1);
        m_stuck = 1'b0;
        issue(C_DS, 4'h0, 16'h0);
        chk(err == 1'b0, "R11 err cleared on accept", err, 0);
        finish_op();
        chk(r_err == 1'b0, "R11 no error after", r_err, 0);

        chk(v_gap == 0, "R5 select gap", v_gap, 0);
        chk(v_time == 0, "R8 half-period lengths", v_time, 0);
        chk(v_idle == 0, "R8 clock low when deselected", v_idle, 0);
        chk(v_di == 0, "R2 data stable in high phase", v_di, 0);
        chk(v_pulse == 0, "R10 done width", v_pulse, 0);
        chk(v_dcs == 0, "R7 done with select fall", v_dcs, 0);

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end
endmodule